// File: doc/BRIEF.md
# Alarm Real-Time Counter

This peripheral keeps a 64-bit time value in nanoseconds that grows by a fixed step on every clock. Software reaches it over a small 32-bit register bus: it can read or overwrite either half of the time, load a 64-bit alarm, arm that alarm, disarm it, and enable or acknowledge a level interrupt.

An alarm is armed only by writing its low word. The upper word is loaded first and has no side effect. When armed, an alarm that is already due (at or before the current time) fires in the same cycle. Otherwise a running flag waits until the time reaches the alarm. Firing drops the running flag and sets a pending flag. The interrupt pin is the pending flag gated by a one-bit enable.

Reads return data one cycle after the request. Reading the low time word also latches the upper word into a shadow register, so a low-then-high pair always forms one coherent 64-bit sample, even when a carry crosses the halves between the two reads.

Top module: `rtc_alarm_timer`

## Requirements
- R1: The time value grows by NS_PER_CLK on every clock that carries no time write, and the carry propagates from the low word into the high word.
- R2: A write to the time low word (offset 0x00) replaces bits 31:0 and keeps bits 63:32. A write to the time high word (offset 0x04) replaces bits 63:32 and keeps bits 31:0. The written value is present on the next clock.
- R3: A read of offset 0x00 returns time bits 31:0 and latches bits 63:32 of the same sample. A read of offset 0x04 returns that latched word.
- R4: A write to the alarm high word (offset 0x0C) stores alarm bits 63:32 and changes neither the running flag nor the pending flag.
- R5: A write to the alarm low word (offset 0x08) stores alarm bits 31:0 and then evaluates the alarm. If the alarm is at or before the current time, the pending flag sets and the running flag clears. Otherwise the running flag sets.
- R6: While the running flag is set and the time is at or past the alarm, the running flag clears and the pending flag sets.
- R7: The interrupt pin is high exactly when both the pending flag and the enable are set. A write to offset 0x10 loads the enable from data bit 0 only, and a read of 0x10 returns the enable in bit 0.
- R8: A write to offset 0x14 clears the running flag and leaves the pending flag alone. A write to offset 0x1C clears the pending flag. A read of offset 0x18 returns the running flag in bit 0.
- R9: Reads of offsets 0x14, 0x1C and any offset not listed above return 0. Writes to unlisted offsets change no state.
- R10: After reset the alarm, running flag, pending flag and enable are all 0, and the time equals TIME_RESET.
- R11: Read data appears on the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after a read |
| irqOut | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an alarm that matches the time at exactly the cycle of evaluation, or one nanosecond after it. The time never stops, so the stimulus first writes a known value into the time and then arms the alarm a fixed number of back-to-back bus cycles later. This makes the time at the comparison edge known exactly. The coherent split read has a similar problem: it needs a carry between the two reads. The bench parks the low word just below its wrap and leaves one idle cycle between the low read and the high read.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // register byte offsets
  localparam int OFF_TIME_LO  = 'h00;
  localparam int OFF_TIME_HI  = 'h04;
  localparam int OFF_ALARM_LO = 'h08;
  localparam int OFF_ALARM_HI = 'h0C;
  localparam int OFF_ENABLE   = 'h10;
  localparam int OFF_DISARM   = 'h14;
  localparam int OFF_STATUS   = 'h18;
  localparam int OFF_ACK      = 'h1C;

  localparam int TIME_W = 64;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_ALARM_LO,
    SEL_ALARM_HI,
    SEL_ENABLE,
    SEL_STATUS
  } rd_sel_e;

  typedef struct packed {
    logic    timeLoWr;
    logic    timeHiWr;
    logic    alarmLoWr;
    logic    alarmHiWr;
    logic    enableWr;
    logic    disarm;
    logic    ack;
    logic    rdEn;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes
);

  logic wrAcc;
  logic rdAcc;
  int   offs;

  assign wrAcc = busValid && busWrite;
  assign rdAcc = busValid && !busWrite;
  assign offs  = int'(busAddr);

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = SEL_ZERO;
    strobes.rdEn      = rdAcc;
    strobes.timeLoWr  = wrAcc && (offs == OFF_TIME_LO);
    strobes.timeHiWr  = wrAcc && (offs == OFF_TIME_HI);
    strobes.alarmLoWr = wrAcc && (offs == OFF_ALARM_LO);
    strobes.alarmHiWr = wrAcc && (offs == OFF_ALARM_HI);
    strobes.enableWr  = wrAcc && (offs == OFF_ENABLE);
    strobes.disarm    = wrAcc && (offs == OFF_DISARM);
    strobes.ack       = wrAcc && (offs == OFF_ACK);
    if (rdAcc) begin
      case (offs)
        OFF_TIME_LO:  strobes.rdSel = SEL_TIME_LO;
        OFF_TIME_HI:  strobes.rdSel = SEL_TIME_HI;
        OFF_ALARM_LO: strobes.rdSel = SEL_ALARM_LO;
        OFF_ALARM_HI: strobes.rdSel = SEL_ALARM_HI;
        OFF_ENABLE:   strobes.rdSel = SEL_ENABLE;
        OFF_STATUS:   strobes.rdSel = SEL_STATUS;
        default:      strobes.rdSel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter logic [TIME_W-1:0] NS_PER_CLK = 64'd10,
  parameter logic [TIME_W-1:0] TIME_RESET = 64'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irqOut,
  output logic [TIME_W-1:0] timeCount,
  output logic [TIME_W-1:0] alarmVal,
  output logic              runFlag,
  output logic              pendFlag
);

  localparam int HALF = TIME_W / 2;

  logic [TIME_W-1:0] timeNext;
  logic [TIME_W-1:0] armVal;
  logic [HALF-1:0]   shadowHi;
  logic [WORD_W-1:0] rdMux;
  logic              enBit;
  logic              hitNow;
  logic              armDue;
  logic              runNext;
  logic              pendNext;

  // time update: one half replaced on a write, otherwise a step
  always_comb begin
    timeNext = timeCount + NS_PER_CLK;
    if (strobes.timeLoWr) timeNext = {timeCount[TIME_W-1:HALF], wdata};
    if (strobes.timeHiWr) timeNext = {wdata, timeCount[HALF-1:0]};
  end

  // alarm evaluation and flag updates
  assign armVal = {alarmVal[TIME_W-1:HALF], wdata};
  assign armDue = armVal <= timeCount;
  assign hitNow = runFlag && (timeCount >= alarmVal);

  always_comb begin
    runNext  = runFlag;
    pendNext = pendFlag;
    if (strobes.ack)    pendNext = 1'b0;
    if (hitNow) begin
      runNext  = 1'b0;
      pendNext = 1'b1;
    end
    if (strobes.disarm) runNext = 1'b0;
    if (strobes.alarmLoWr) begin
      if (armDue) begin
        runNext  = 1'b0;
        pendNext = 1'b1;
      end else begin
        runNext  = 1'b1;
      end
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_TIME_LO:  rdMux = timeCount[HALF-1:0];
      SEL_TIME_HI:  rdMux = shadowHi;
      SEL_ALARM_LO: rdMux = alarmVal[HALF-1:0];
      SEL_ALARM_HI: rdMux = alarmVal[TIME_W-1:HALF];
      SEL_ENABLE:   rdMux = {{(WORD_W-1){1'b0}}, enBit};
      SEL_STATUS:   rdMux = {{(WORD_W-1){1'b0}}, runFlag};
      default:      rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeCount <= TIME_RESET;
      alarmVal  <= '0;
      runFlag   <= 1'b0;
      pendFlag  <= 1'b0;
      enBit     <= 1'b0;
      shadowHi  <= '0;
      rdata     <= '0;
    end else begin
      timeCount <= timeNext;
      runFlag   <= runNext;
      pendFlag  <= pendNext;
      if (strobes.alarmLoWr) alarmVal[HALF-1:0]      <= wdata;
      if (strobes.alarmHiWr) alarmVal[TIME_W-1:HALF] <= wdata;
      if (strobes.enableWr)  enBit <= wdata[0];
      if (strobes.rdEn) begin
        rdata <= rdMux;
        if (strobes.rdSel == SEL_TIME_LO) shadowHi <= timeCount[TIME_W-1:HALF];
      end
    end
  end

  assign irqOut = pendFlag & enBit;

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_alarm_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [63:0]       NS_PER_CLK = 64'd10,
  parameter logic [63:0]       TIME_RESET = 64'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);

  strobe_t           strobes;
  logic [TIME_W-1:0] timeCount;
  logic [TIME_W-1:0] alarmVal;
  logic              runFlag;
  logic              pendFlag;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  rtc_alarm_dp #(.NS_PER_CLK(NS_PER_CLK), .TIME_RESET(TIME_RESET)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wdata     (busWdata),
    .rdata     (busRdata),
    .irqOut    (irqOut),
    .timeCount (timeCount),
    .alarmVal  (alarmVal),
    .runFlag   (runFlag),
    .pendFlag  (pendFlag)
  );

endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk
  import rtc_alarm_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [63:0] NS_PER_CLK = 64'd10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [63:0]       timeCount,
  input logic [63:0]       alarmVal,
  input logic              runFlag,
  input logic              pendFlag
);

  logic wrAcc, rdAcc, timeWr, armWr, mapped;
  assign wrAcc  = busValid && busWrite;
  assign rdAcc  = busValid && !busWrite;
  assign timeWr = wrAcc && (int'(busAddr) == OFF_TIME_LO || int'(busAddr) == OFF_TIME_HI);
  assign armWr  = wrAcc && (int'(busAddr) == OFF_ALARM_LO);
  assign mapped = int'(busAddr) == OFF_TIME_LO  || int'(busAddr) == OFF_TIME_HI ||
                  int'(busAddr) == OFF_ALARM_LO || int'(busAddr) == OFF_ALARM_HI ||
                  int'(busAddr) == OFF_ENABLE   || int'(busAddr) == OFF_STATUS;

  // R1
  a_r1_time_step: assert property (@(posedge clk) disable iff (!rst_n)
    !timeWr |=> timeCount == $past(timeCount) + NS_PER_CLK);

  // R5
  a_r5_due_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armWr && ({alarmVal[63:32], busWdata} <= timeCount)) |=> (pendFlag && !runFlag));

  // R6
  a_r6_reach_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (runFlag && (timeCount >= alarmVal) && !armWr) |=> (pendFlag && !runFlag));

  // R8
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAcc && int'(busAddr) == OFF_DISARM) |=> !runFlag);

  // R8
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAcc && int'(busAddr) == OFF_ACK && !(runFlag && timeCount >= alarmVal)) |=> !pendFlag);

  // R9
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAcc && !mapped) |=> busRdata == 32'd0);

  // R4
  a_r4_hi_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wrAcc && int'(busAddr) == OFF_ALARM_HI && !runFlag) |=> !runFlag);

endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.ADDR_W(ADDR_W), .NS_PER_CLK(NS_PER_CLK)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .timeCount (timeCount),
  .alarmVal  (alarmVal),
  .runFlag   (runFlag),
  .pendFlag  (pendFlag)
);

// File: tb/rtc_alarm_timer_test.sv
module rtc_alarm_timer_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 6;
  localparam logic [63:0] STEP       = 64'd10;
  localparam logic [63:0] T_RST      = 64'h0000_0003_0000_0040;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              irqOut;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_timer #(.ADDR_W(ADDR_W), .NS_PER_CLK(STEP), .TIME_RESET(T_RST)) uut (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int offs, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = ADDR_W'(offs); busWdata = d;
    @(posedge clk); @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input int offs, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = ADDR_W'(offs);
    @(posedge clk); @(negedge clk);
    d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd('h00, d); chk("R10 time low after reset", d, T_RST[31:0]);
    rd('h04, d); chk("R10 time high after reset", d, T_RST[63:32]);
    rd('h08, d); chk("R10 alarm low", d, 0);
    rd('h0C, d); chk("R10 alarm high", d, 0);
    rd('h10, d); chk("R10 enable", d, 0);
    rd('h18, d); chk("R10 running", d, 0);
    chk("R10 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b, c;
    rd('h00, a);
    rd('h00, b); chk("R1 step per clock", b, a + 32'd10);
    idle(3);
    rd('h00, c); chk("R11 R1 step over idle", c, b + 32'd40);
    chk("R11 data held", busRdata, c);
  endtask

  task automatic t_time_write();
    logic [31:0] d;
    wr('h04, 32'h1234_5678);
    wr('h00, 32'h0000_0100);
    rd('h00, d); chk("R2 time low written", d, 32'h0000_0100);
    rd('h04, d); chk("R2 time high written", d, 32'h1234_5678);
    wr('h00, 32'h0000_0200);
    rd('h00, d); chk("R2 low write keeps high low", d, 32'h0000_0200);
    rd('h04, d); chk("R2 low write keeps high", d, 32'h1234_5678);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    wr('h04, 32'h1);
    wr('h00, 32'hFFFF_FFF0);
    rd('h00, d); chk("R3 low before carry", d, 32'hFFFF_FFF0);
    idle(1);
    rd('h04, d); chk("R3 shadow high across carry", d, 32'h1);
    rd('h00, d); chk("R1 carry into low", d, 32'h0000_000E);
    rd('h04, d); chk("R3 R1 carry into high", d, 32'h2);
  endtask

  task automatic t_alarm_hi();
    logic [31:0] d;
    wr('h10, 32'h1);
    wr('h04, 32'h0);
    wr('h0C, 32'h5);
    rd('h18, d); chk("R4 high write does not arm", d, 0);
    rd('h0C, d); chk("R4 high word stored", d, 32'h5);
    chk("R4 no irq", {31'b0, irqOut}, 0);
    wr('h0C, 32'h0);
  endtask

  task automatic t_alarm_future();
    logic [31:0] d;
    wr('h04, 32'h0);
    wr('h00, 32'd1000);
    wr('h08, 32'd1050);
    chk("R5 future alarm not fired", {31'b0, irqOut}, 0);
    idle(4);
    chk("R6 not yet reached", {31'b0, irqOut}, 0);
    idle(1);
    chk("R6 fires on reach", {31'b0, irqOut}, 1);
    rd('h18, d); chk("R6 running cleared", d, 0);
    wr('h1C, 32'h0);
    chk("R8 ack clears pending", {31'b0, irqOut}, 0);
  endtask

  task automatic t_alarm_edges();
    wr('h00, 32'd2000);
    wr('h08, 32'd2000);
    chk("R5 equal alarm fires at once", {31'b0, irqOut}, 1);
    wr('h1C, 32'h0);
    wr('h00, 32'd3000);
    wr('h08, 32'd3001);
    chk("R5 one ns ahead not fired", {31'b0, irqOut}, 0);
    idle(1);
    chk("R6 one ns ahead fires next", {31'b0, irqOut}, 1);
    wr('h1C, 32'h0);
  endtask

  task automatic t_disarm();
    logic [31:0] d;
    wr('h0C, 32'h0000_FFFF);
    wr('h08, 32'h0);
    rd('h18, d); chk("R5 far alarm running", d, 1);
    wr('h14, 32'h0);
    rd('h18, d); chk("R8 disarm clears running", d, 0);
    chk("R8 no irq after disarm", {31'b0, irqOut}, 0);
    wr('h0C, 32'h0);
    wr('h08, 32'h0);
    chk("R5 past alarm fires", {31'b0, irqOut}, 1);
    wr('h14, 32'h0);
    chk("R8 disarm keeps pending", {31'b0, irqOut}, 1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr('h10, 32'h0);
    chk("R7 irq gated off", {31'b0, irqOut}, 0);
    wr('h10, 32'hFFFF_FFFE);
    rd('h10, d); chk("R7 only bit0 kept", d, 0);
    chk("R7 irq still off", {31'b0, irqOut}, 0);
    wr('h10, 32'h3);
    rd('h10, d); chk("R7 enable reads 1", d, 1);
    chk("R7 irq on", {31'b0, irqOut}, 1);
    wr('h1C, 32'h0);
    chk("R8 ack drops irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd('h14, d); chk("R9 disarm reads 0", d, 0);
    rd('h1C, d); chk("R9 ack reads 0", d, 0);
    rd('h20, d); chk("R9 unmapped reads 0", d, 0);
    rd('h02, d); chk("R9 misaligned reads 0", d, 0);
    wr('h24, 32'hDEAD_BEEF);
    wr('h09, 32'h1234_0000);
    rd('h08, d); chk("R9 alarm low untouched", d, 0);
    rd('h0C, d); chk("R9 alarm high untouched", d, 0);
    rd('h10, d); chk("R9 enable untouched", d, 1);
    rd('h18, d); chk("R9 running untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_time_write();
    t_shadow();
    t_alarm_hi();
    t_alarm_future();
    t_alarm_edges();
    t_disarm();
    t_enable();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule